// File: doc/BRIEF.md
# Byte access controller for a nibble-wide page-mode DRAM

This block sits between a simple byte-oriented request port and a single asynchronous DRAM that stores four bits per location. The DRAM has 256K locations, one multiplexed address bus, and active-low row strobe, column strobe, output enable and write enable pins. A client presents a 16-bit byte address, an operation code and, for writes, the data. The controller then runs the strobe sequence. Each byte uses one row cycle. The upper address byte is the row. The lower address byte is the column, and it is strobed twice in page mode, once per nibble. The ninth multiplexed line is not part of the client address: it selects which of the two nibble locations is addressed, so the two halves of a byte sit at distinct DRAM cells.

Word operations move two bytes at consecutive addresses, low byte first, as two back-to-back row cycles. The controller reports the address that follows the access, so a caller can walk a buffer. Byte operations can request a post-increment of one. A request/ready handshake admits a new operation only when the controller is idle. Ready stays low from acceptance until the row strobe has been released and the precharge time has elapsed.

Top module: `nib_dram_ctrl`

## Requirements
- R1: After reset and whenever no operation runs, dr_ras_n, dr_cas_n, dr_oe_n and dr_we_n are 1, dr_dq_oe is 0, req_ready is 1 and done is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 for 4+2*WAIT_CYC+PRE_CYC cycles per byte moved. done is 1 for exactly one cycle after the last byte, and req_ready is 1 in that cycle, so a new request can be taken in the same cycle.
- R3: dr_ma carries the row {1'b0, addr[15:8]} in the cycle before dr_ras_n falls and in the cycle it falls. Column accesses present {sel, addr[7:0]}, where sel=1 addresses the high nibble. dr_cas_n is only low while dr_ras_n is low, and dr_ma is stable while dr_cas_n is low.
- R4: A byte read keeps dr_oe_n low and dr_we_n high through two column accesses of one row cycle. Each access holds dr_cas_n low for WAIT_CYC cycles, with a cycle of dr_cas_n high between them. The first access uses sel=1 and its nibble becomes bits 7:4. The second uses sel=0 and its nibble becomes bits 3:0. dr_dq_i is sampled at the last low cycle of each access.
- R5: A byte write keeps dr_we_n low, dr_dq_oe high and dr_oe_n high through both column accesses. The low nibble is written first with sel=0, then the high nibble with sel=1, and dr_dq_o holds the nibble throughout its access.
- R6: After the second column access, dr_ras_n, dr_cas_n, dr_oe_n and dr_we_n all return to 1 and dr_dq_oe to 0. They stay so for PRE_CYC cycles before the next row cycle or the end of the operation.
- R7: dr_oe_n is never 0 while dr_dq_oe is 1, and dr_dq_oe is 0 in the cycle before dr_oe_n falls.
- R8: req_op encodes 2'b00 byte read, 2'b01 byte write, 2'b10 word read and 2'b11 word write. A byte read returns {8'h00, byte} on rd_data, and a byte write stores req_wdata[7:0]. Read data is valid in the done cycle.
- R9: Word operations use the byte at req_addr as bits 7:0 and the byte at req_addr+1 (modulo 2^16) as bits 15:8, for both rd_data and req_wdata. next_addr is req_addr+2, and req_inc has no effect on them.
- R10: In the done cycle of a byte operation, next_addr is req_addr+1 when req_inc was 1 and req_addr when it was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_op | input | 2 | Operation code (see R8) |
| req_inc | input | 1 | Post-increment for byte operations |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (byte in 7:0, word in 15:0) |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| next_addr | output | 16 | Address following the access, valid with done |
| dr_ras_n | output | 1 | Row strobe, active low |
| dr_cas_n | output | 1 | Column strobe, active low |
| dr_oe_n | output | 1 | DRAM output enable, active low |
| dr_we_n | output | 1 | DRAM write enable, active low |
| dr_ma | output | 9 | Multiplexed DRAM address |
| dr_dq_o | output | 4 | Data driven toward the DRAM |
| dr_dq_oe | output | 1 | Controller drives the data bus |
| dr_dq_i | input | 4 | Data returned by the DRAM |

## Verification
Completion of one operation and acceptance of the next can fall in the same cycle. done and req_ready are both high then, and the next row setup starts on that edge. The bench provokes this by holding req_valid high with a fresh request right after each acceptance. Random idle gaps of zero to two cycles are mixed in. The overlap is judged on that cycle: rd_data and next_addr must still show the finished operation, and the following cycle must show the new row address with dr_ras_n high. A write directly followed by a read is judged the same way against R7, the handover of the data bus to the DRAM.

// File: rtl/nib_dram_pkg.sv
package nib_dram_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        OP_RD_BYTE = 2'b00,
        OP_WR_BYTE = 2'b01,
        OP_RD_WORD = 2'b10,
        OP_WR_WORD = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_COL,
        ST_CAS,
        ST_PRE
    } st_e;

    typedef struct packed {
        logic is_wr;
        logic is_word;
        logic inc;
    } opinfo_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, oe_n: 1'b1,
                                        we_n: 1'b1, dq_oe: 1'b0};

    function automatic opinfo_t decode_op(input logic [1:0] op, input logic inc);
        opinfo_t r;
        r.is_wr   = op[0];
        r.is_word = op[1];
        r.inc     = inc;
        return r;
    endfunction

    // 1 selects the high-nibble location. Reads fetch high first,
    // writes store low first.
    function automatic logic hi_nib_sel(input logic is_wr, input logic nib_idx);
        return is_wr ? nib_idx : ~nib_idx;
    endfunction

endpackage

// File: rtl/nib_dram_seq.sv
module nib_dram_seq
    import nib_dram_pkg::*;
#(
    parameter int WAIT_CYC = 2,
    parameter int PRE_CYC  = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  opinfo_t op_in,
    output st_e     st,
    output opinfo_t op,
    output logic    nib,
    output logic    byte_idx,
    output logic    sample,
    output logic    byte_end,
    output logic    done,
    output logic    ready
);
    localparam int CNT_MAX = (WAIT_CYC > PRE_CYC) ? WAIT_CYC : PRE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_CYC - 1);

    st_e              st_q;
    logic [CNT_W-1:0] cnt;
    logic             wait_end;
    logic             pre_end;
    logic             last_byte;

    assign st        = st_q;
    assign wait_end  = (st_q == ST_CAS) && (cnt == WAIT_LAST);
    assign pre_end   = (st_q == ST_PRE) && (cnt == PRE_LAST);
    assign last_byte = !op.is_word || byte_idx;
    assign sample    = wait_end && !op.is_wr;
    assign byte_end  = pre_end;
    assign ready     = (st_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt      <= '0;
            nib      <= 1'b0;
            byte_idx <= 1'b0;
            op       <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        op       <= op_in;
                        byte_idx <= 1'b0;
                        nib      <= 1'b0;
                        st_q     <= ST_ROW;
                    end
                end
                ST_ROW: st_q <= ST_RAS;
                ST_RAS: st_q <= ST_COL;
                ST_COL: begin
                    cnt  <= '0;
                    st_q <= ST_CAS;
                end
                ST_CAS: begin
                    if (wait_end) begin
                        cnt <= '0;
                        if (!nib) begin
                            nib  <= 1'b1;
                            st_q <= ST_COL;
                        end else begin
                            nib  <= 1'b0;
                            st_q <= ST_PRE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PRE: begin
                    if (pre_end) begin
                        cnt <= '0;
                        if (last_byte) begin
                            st_q <= ST_IDLE;
                            done <= 1'b1;
                        end else begin
                            byte_idx <= 1'b1;
                            st_q     <= ST_ROW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assert_done_ready_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> ready);
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_wait_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CAS) |-> (cnt <= WAIT_LAST));
    assert_pre_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PRE) |-> (cnt <= PRE_LAST));

endmodule

// File: rtl/nib_dram_addr.sv
module nib_dram_addr
    import nib_dram_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int HALF  = ADDR_W / 2,
    localparam int MA_W  = HALF + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              advance,
    input  st_e               st,
    input  logic              hi_sel,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [MA_W-1:0]   ma
);
    logic row_phase;

    assign row_phase = (st == ST_IDLE) || (st == ST_ROW) || (st == ST_RAS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
        end else if (load) begin
            cur_addr <= addr_in;
        end else if (advance) begin
            cur_addr <= cur_addr + 1'b1;
        end
    end

    always_comb begin
        if (row_phase) begin
            ma = {1'b0, cur_addr[ADDR_W-1 -: HALF]};
        end else begin
            ma = {hi_sel, cur_addr[HALF-1:0]};
        end
    end

    assert_step_one_R10: assert property (@(posedge clk) disable iff (rst)
        (advance && !load) |=> (cur_addr == $past(cur_addr) + 1'b1));

endmodule

// File: rtl/nib_dram_data.sv
module nib_dram_data
    import nib_dram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] wdata,
    input  logic              sample,
    input  logic              byte_idx,
    input  logic              hi_sel,
    input  logic [NIB_W-1:0]  dq_i,
    output logic [NIB_W-1:0]  dq_o,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] wq;
    logic [BYTE_W-1:0] wbyte;
    logic [1:0]        pos;

    assign wbyte = byte_idx ? wq[WORD_W-1 -: BYTE_W] : wq[BYTE_W-1:0];
    assign dq_o  = hi_sel ? wbyte[BYTE_W-1 -: NIB_W] : wbyte[NIB_W-1:0];
    assign pos   = {byte_idx, hi_sel};

    always_ff @(posedge clk) begin
        if (rst) begin
            wq      <= '0;
            rd_data <= '0;
        end else if (start) begin
            wq      <= wdata;
            rd_data <= '0;
        end else if (sample) begin
            rd_data[pos*NIB_W +: NIB_W] <= dq_i;
        end
    end

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> (rd_data == '0));

endmodule

// File: rtl/nib_dram_ctrl.sv
module nib_dram_ctrl
    import nib_dram_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WAIT_CYC = 2,
    parameter int PRE_CYC  = 2,
    localparam int MA_W    = ADDR_W / 2 + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic              req_inc,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              done,
    output logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] next_addr,
    output logic              dr_ras_n,
    output logic              dr_cas_n,
    output logic              dr_oe_n,
    output logic              dr_we_n,
    output logic [MA_W-1:0]   dr_ma,
    output logic [NIB_W-1:0]  dr_dq_o,
    output logic              dr_dq_oe,
    input  logic [NIB_W-1:0]  dr_dq_i
);
    st_e     st;
    opinfo_t op;
    logic    nib;
    logic    byte_idx;
    logic    sample;
    logic    byte_end;
    logic    start;
    logic    hi_sel;
    logic    col_phase;
    strobe_t strb;

    assign start  = req_valid && req_ready;
    assign hi_sel = hi_nib_sel(op.is_wr, nib);

    nib_dram_seq #(
        .WAIT_CYC (WAIT_CYC),
        .PRE_CYC  (PRE_CYC)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .op_in    (decode_op(req_op, req_inc)),
        .st       (st),
        .op       (op),
        .nib      (nib),
        .byte_idx (byte_idx),
        .sample   (sample),
        .byte_end (byte_end),
        .done     (done),
        .ready    (req_ready)
    );

    nib_dram_addr #(
        .ADDR_W (ADDR_W)
    ) addr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .addr_in  (req_addr),
        .advance  (byte_end && (op.is_word || op.inc)),
        .st       (st),
        .hi_sel   (hi_sel),
        .cur_addr (next_addr),
        .ma       (dr_ma)
    );

    nib_dram_data data_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .wdata    (req_wdata),
        .sample   (sample),
        .byte_idx (byte_idx),
        .hi_sel   (hi_sel),
        .dq_i     (dr_dq_i),
        .dq_o     (dr_dq_o),
        .rd_data  (rd_data)
    );

    assign col_phase = (st == ST_COL) || (st == ST_CAS);

    always_comb begin
        strb = STROBE_IDLE;
        if ((st == ST_RAS) || col_phase) begin
            strb.ras_n = 1'b0;
        end
        if (st == ST_CAS) begin
            strb.cas_n = 1'b0;
        end
        if (col_phase) begin
            if (op.is_wr) begin
                strb.we_n  = 1'b0;
                strb.dq_oe = 1'b1;
            end else begin
                strb.oe_n = 1'b0;
            end
        end
    end

    assign dr_ras_n = strb.ras_n;
    assign dr_cas_n = strb.cas_n;
    assign dr_oe_n  = strb.oe_n;
    assign dr_we_n  = strb.we_n;
    assign dr_dq_oe = strb.dq_oe;

    assert_cas_in_ras_R3: assert property (@(posedge clk) disable iff (rst)
        !dr_cas_n |-> !dr_ras_n);
    assert_row_setup_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(dr_ras_n) |-> $stable(dr_ma));
    assert_col_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!dr_cas_n && $past(!dr_cas_n)) |-> $stable(dr_ma));
    assert_sample_window_R4: assert property (@(posedge clk) disable iff (rst)
        sample |-> (!dr_cas_n && !dr_oe_n && dr_we_n));
    assert_we_oe_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(!dr_we_n && !dr_oe_n));
    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(dr_ras_n) |-> (dr_cas_n && dr_oe_n && dr_we_n && !dr_dq_oe));
    assert_no_fight_R7: assert property (@(posedge clk) disable iff (rst)
        !dr_oe_n |-> !dr_dq_oe);
    assert_bus_gap_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(dr_oe_n) |-> !$past(dr_dq_oe));
    assert_busy_R2: assert property (@(posedge clk) disable iff (rst)
        !dr_ras_n |-> !req_ready);

endmodule

// File: tb/nib_dram_ctrl_tb_top.sv
module nib_dram_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WAITS      = 2;
    localparam int PRECH      = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic        req_inc = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [15:0] req_wdata = 16'h0;
    logic        done;
    logic [15:0] rd_data;
    logic [15:0] next_addr;
    logic        dr_ras_n, dr_cas_n, dr_oe_n, dr_we_n, dr_dq_oe;
    logic [8:0]  dr_ma;
    logic [3:0]  dr_dq_o;
    logic [3:0]  dr_dq_i = 4'h0;

    int vectors = 0;
    int fails   = 0;
    bit run     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nib_dram_ctrl #(.ADDR_W(16), .WAIT_CYC(WAITS), .PRE_CYC(PRECH)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_inc(req_inc), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
        .next_addr(next_addr), .dr_ras_n(dr_ras_n), .dr_cas_n(dr_cas_n),
        .dr_oe_n(dr_oe_n), .dr_we_n(dr_we_n), .dr_ma(dr_ma),
        .dr_dq_o(dr_dq_o), .dr_dq_oe(dr_dq_oe), .dr_dq_i(dr_dq_i)
    );

    // ---------------- nibble memory model ----------------
    logic [3:0] nmem [logic [16:0]];
    logic [7:0] row_l = 8'h0;
    logic       ras_d = 1'b1;
    logic       cas_d = 1'b1;

    always @(negedge clk) begin
        logic [16:0] k;
        if (!dr_ras_n && ras_d) row_l = dr_ma[7:0];
        k = {dr_ma[8], row_l, dr_ma[7:0]};
        if (!dr_cas_n && cas_d && !dr_we_n) nmem[k] = dr_dq_o;
        if (!dr_cas_n && !dr_oe_n) dr_dq_i = nmem.exists(k) ? nmem[k] : 4'h0;
        else dr_dq_i = 4'h0;
        ras_d = dr_ras_n;
        cas_d = dr_cas_n;
    end

    // ---------------- behavioural reference ----------------
    logic [7:0] shadow [logic [15:0]];

    function automatic logic [7:0] sh_get(input logic [15:0] a);
        return shadow.exists(a) ? shadow[a] : 8'h00;
    endfunction

    typedef struct {
        logic [4:0]  strb;   // ras_n, cas_n, oe_n, we_n, dq_oe
        logic        rdy;
        logic        dn;
        logic        ma_chk;
        logic [8:0]  ma;
        logic        dq_chk;
        logic [3:0]  dq;
        logic        res_chk;
        logic        rd_chk;
        logic [15:0] rd;
        logic [15:0] nxt;
        string       tag;
    } exp_t;

    exp_t expq[$];

    function automatic exp_t mk(input logic [4:0] s, input logic rdy,
                                input logic dn, input string tag);
        exp_t e;
        e.strb = s; e.rdy = rdy; e.dn = dn;
        e.ma_chk = 1'b0; e.ma = '0; e.dq_chk = 1'b0; e.dq = '0;
        e.res_chk = 1'b0; e.rd_chk = 1'b0; e.rd = '0; e.nxt = '0;
        e.tag = tag;
        return e;
    endfunction

    task automatic push_byte(input bit wr, input logic [15:0] a, input logic [7:0] wb);
        exp_t e;
        logic [4:0] cs;
        e = mk(5'b11110, 1'b0, 1'b0, "R3");
        e.ma_chk = 1'b1; e.ma = {1'b0, a[15:8]};
        expq.push_back(e);
        e.strb = 5'b01110;
        expq.push_back(e);
        cs = wr ? 5'b01101 : 5'b01010;
        for (int n = 0; n < 2; n++) begin
            logic sel;
            sel = wr ? n[0] : ~n[0];
            e = mk(cs, 1'b0, 1'b0, wr ? "R5" : "R4");
            e.ma_chk = 1'b1; e.ma = {sel, a[7:0]};
            e.dq_chk = wr; e.dq = sel ? wb[7:4] : wb[3:0];
            expq.push_back(e);
            e.strb = cs & 5'b10111;
            for (int w = 0; w < WAITS; w++) expq.push_back(e);
        end
        for (int p = 0; p < PRECH; p++) expq.push_back(mk(5'b11110, 1'b0, 1'b0, "R6"));
    endtask

    task automatic push_op(input logic [1:0] op, input logic inc,
                           input logic [15:0] a, input logic [15:0] wd);
        exp_t e;
        logic [15:0] a1;
        a1 = a + 16'd1;
        e = mk(5'b11110, 1'b1, 1'b1, "R2");
        e.res_chk = 1'b1;
        case (op)
            2'b00: begin
                e.rd_chk = 1'b1; e.rd = {8'h00, sh_get(a)};
                e.nxt = inc ? a1 : a;
                push_byte(1'b0, a, 8'h00);
            end
            2'b01: begin
                push_byte(1'b1, a, wd[7:0]);
                shadow[a] = wd[7:0];
                e.nxt = inc ? a1 : a;
            end
            2'b10: begin
                e.rd_chk = 1'b1; e.rd = {sh_get(a1), sh_get(a)};
                e.nxt = a + 16'd2;
                push_byte(1'b0, a, 8'h00);
                push_byte(1'b0, a1, 8'h00);
            end
            default: begin
                push_byte(1'b1, a, wd[7:0]);
                push_byte(1'b1, a1, wd[15:8]);
                shadow[a]  = wd[7:0];
                shadow[a1] = wd[15:8];
                e.nxt = a + 16'd2;
            end
        endcase
        e.tag = op[1] ? "R9" : ((op[0] == 1'b0) ? "R8" : "R10");
        expq.push_back(e);
    endtask

    // per-clock comparison
    always @(negedge clk) begin
        exp_t e;
        logic [4:0] act;
        if (run && !rst) begin
            if (expq.size() > 0) e = expq.pop_front();
            else e = mk(5'b11110, 1'b1, 1'b0, "R1");
            act = {dr_ras_n, dr_cas_n, dr_oe_n, dr_we_n, dr_dq_oe};
            vectors++;
            if (act !== e.strb || req_ready !== e.rdy || done !== e.dn ||
                (e.ma_chk && dr_ma !== e.ma) || (e.dq_chk && dr_dq_o !== e.dq)) begin
                fails++;
                $display("FAIL %s: strobes/rdy/done/ma/dq actual=%b %b %b %h %h expected=%b %b %b %h %h",
                         e.tag, act, req_ready, done, dr_ma, dr_dq_o,
                         e.strb, e.rdy, e.dn, e.ma, e.dq);
            end
            if (e.res_chk) begin
                vectors++;
                if (next_addr !== e.nxt) begin
                    fails++;
                    $display("FAIL %s: next_addr actual=%h expected=%h", e.tag, next_addr, e.nxt);
                end
            end
            if (e.rd_chk) begin
                vectors++;
                if (rd_data !== e.rd) begin
                    fails++;
                    $display("FAIL %s: rd_data actual=%h expected=%h", e.tag, rd_data, e.rd);
                end
            end
            if (req_valid && req_ready) push_op(req_op, req_inc, req_addr, req_wdata);
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic [1:0] op, input logic inc,
                         input logic [15:0] a, input logic [15:0] wd);
        req_valid = 1'b1; req_op = op; req_inc = inc; req_addr = a; req_wdata = wd;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish actual=hung expected=complete");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        if ({dr_ras_n, dr_cas_n, dr_oe_n, dr_we_n, dr_dq_oe, req_ready, done} !== 7'b1111010) begin
            fails++;
            $display("FAIL R1: reset state actual=%b expected=%b",
                     {dr_ras_n, dr_cas_n, dr_oe_n, dr_we_n, dr_dq_oe, req_ready, done}, 7'b1111010);
        end
        @(posedge clk); #1;
        rst = 1'b0; run = 1'b1;
        gap(2);
        // R8 R10: byte write/read without and with post-increment
        issue(2'b01, 1'b0, 16'h1234, 16'h00A5);
        gap(2);
        issue(2'b00, 1'b0, 16'h1234, 16'h0000);
        issue(2'b01, 1'b1, 16'h1235, 16'hFF3C);
        issue(2'b00, 1'b1, 16'h1235, 16'h0000);
        gap(1);
        // R9: words, inc ignored, low byte at lower address
        issue(2'b11, 1'b0, 16'h4000, 16'hBEEF);
        issue(2'b10, 1'b1, 16'h4000, 16'h0000);
        issue(2'b00, 1'b0, 16'h4001, 16'h0000);
        // R9: wrap at top of address space
        issue(2'b11, 1'b1, 16'hFFFF, 16'h1357);
        issue(2'b10, 1'b0, 16'hFFFF, 16'h0000);
        issue(2'b00, 1'b1, 16'h0000, 16'h0000);
        // R3: same column in neighbouring rows, same row neighbouring columns
        issue(2'b01, 1'b0, 16'h12FF, 16'h0011);
        issue(2'b01, 1'b0, 16'h13FF, 16'h0022);
        issue(2'b01, 1'b0, 16'h12FE, 16'h0033);
        issue(2'b00, 1'b0, 16'h12FF, 16'h0000);
        issue(2'b00, 1'b0, 16'h13FF, 16'h0000);
        issue(2'b00, 1'b0, 16'h12FE, 16'h0000);
        // R7 and mixed traffic: random ops, gaps 0..2, write->read turnarounds
        for (int i = 0; i < 60; i++) begin
            logic [15:0] a;
            a = {4'h8, 4'($urandom_range(0, 3)), 8'($urandom)};
            issue(2'($urandom), 1'($urandom), a, 16'($urandom));
            gap($urandom_range(0, 2));
        end
        for (int i = 0; i < 20; i++) begin
            logic [15:0] a;
            a = {4'h8, 4'($urandom_range(0, 3)), 8'($urandom)};
            issue(2'b11, 1'b0, a, 16'($urandom));
            issue(2'b10, 1'b0, a, 16'h0000);
        end
        while (expq.size() > 0) @(posedge clk);
        gap(4);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule